// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a clocked host and an external asynchronous static RAM. The host issues one single-word read or write at a time over a valid/ready handshake. The controller then drives the RAM's select lines, address and data bus in a fixed sequence of phases. Each phase lasts a whole number of clock cycles. That number is worked out at elaboration from a nanosecond limit and the clock period: divide, round up, and use at least one cycle.

A write has up to five phases in order: address setup, an optional bus-release gap, the write-enable pulse with data driven, a hold phase, and recovery. The recovery phase only exists if the write-cycle minimum is not yet covered. A read holds the address and both selects, with output enable low, until the slowest of the address, chip-select and output-enable access times has passed. It then captures the bus and waits out the memory's output-disable time before the controller can accept the next request. The data bus leaves the block as separate output, output-enable and input signals so that a pad cell can be placed outside it.

A parameter selects write-enable-only operation, in which output enable stays low at all times. In that mode the controller delays driving the bus until the memory has released it after write enable falls.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and whenever the controller is idle, `mem_sel_n`=1, `mem_sel`=0, `mem_wr_n`=1 and `mem_dq_oe`=0. In idle `req_ready`=1 and `done`=0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 for the whole busy span. For a write the span is setup+gap+pulse+hold+recovery cycles, and for a read it is access+turnaround cycles. Each count is ceil(ns/CLK_NS) with a minimum of 1. With the defaults at 10 ns, a write is busy 4 cycles and a read 3 cycles.
- R3: Data written to an address is stored there at the end of the write, and a later read of that address returns it.
- R4: `mem_wr_n` stays low for at least ceil(T_WP_NS/CLK_NS) cycles. `mem_addr` does not change while `mem_wr_n` is low.
- R5: Write data is driven and stable for at least ceil(T_DS_NS/CLK_NS) cycles before `mem_wr_n` rises. It is still driven in the cycle after the rise.
- R6: Read data is captured only after max(address, select, output-enable access) cycles with all three applied. It is presented on `rd_data`.
- R7: `done` is a single-cycle pulse in the first cycle `req_ready` is 1 again. `rd_data` holds its value after the pulse.
- R8: `mem_dq_oe` is never 1 while the memory may drive the bus. That covers the cycle in which a read is selected and the ceil(max(T_OHZ_NS,T_CHZ_NS)/CLK_NS) cycles after it.
- R9: With WE_ONLY=0, `mem_oe_n` is 1 whenever `mem_wr_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | Request finished (one cycle) |
| rd_data | output | DATA_W | Last captured read word |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_wr_n | output | 1 | Active-low write enable |
| mem_addr | output | ADDR_W | Address to RAM |
| mem_dq_o | output | DATA_W | Data toward RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | DATA_W | Data from RAM |

## Verification
The bench builds the controller with a 4-bit address, 16-bit data, a 10 ns clock, the default nanosecond limits and WE_ONLY=0. With these values the write pulse lasts two cycles, the read access lasts two cycles, and turnaround and hold last one cycle each. Each interval is therefore short enough that shortening it by a single cycle is visible to the bench's memory model. That model returns a poison word when sampled before two cycles of stable access, and it flags contention in the cycle after a read ends. This puts early capture, a missing hold and a missing turnaround gap within reach, and it lets the exact busy spans of 4 and 3 cycles be checked.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WADDR, ST_WGAP, ST_WDATA, ST_WHOLD, ST_WREC, ST_RACC, ST_RTURN
  } st_e;

  // cycles = ceil(ns / period), at least one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: a freshly loaded phase never ends faster than its length
  a_r2_load_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !zero);
endmodule

// File: rtl/asram_seq.sv
module asram_seq import asram_pkg::*; #(
  parameter int CW     = 3,
  parameter int SA_C   = 1,
  parameter int GAP_C  = 0,
  parameter int DATA_C = 1,
  parameter int HOLD_C = 1,
  parameter int REC_C  = 0,
  parameter int RACC_C = 1,
  parameter int TURN_C = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_zero,
  output st_e           st_q,
  output st_e           st_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          finish,
  output logic          req_ready
);
  always_comb begin
    st_d    = st_q;
    capture = 1'b0;
    case (st_q)
      ST_IDLE:  if (req_valid) st_d = req_write ? ST_WADDR : ST_RACC;
      ST_WADDR: if (tmr_zero)  st_d = (GAP_C > 0) ? ST_WGAP : ST_WDATA;
      ST_WGAP:  if (tmr_zero)  st_d = ST_WDATA;
      ST_WDATA: if (tmr_zero)  st_d = ST_WHOLD;
      ST_WHOLD: if (tmr_zero)  st_d = (REC_C > 0) ? ST_WREC : ST_IDLE;
      ST_WREC:  if (tmr_zero)  st_d = ST_IDLE;
      ST_RACC:  if (tmr_zero) begin
                  st_d    = ST_RTURN;
                  capture = 1'b1;
                end
      ST_RTURN: if (tmr_zero)  st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_d)
      ST_WADDR: tmr_val = CW'(SA_C - 1);
      ST_WGAP:  tmr_val = CW'((GAP_C > 0) ? GAP_C - 1 : 0);
      ST_WDATA: tmr_val = CW'(DATA_C - 1);
      ST_WHOLD: tmr_val = CW'(HOLD_C - 1);
      ST_WREC:  tmr_val = CW'((REC_C > 0) ? REC_C - 1 : 0);
      ST_RACC:  tmr_val = CW'(RACC_C - 1);
      ST_RTURN: tmr_val = CW'(TURN_C - 1);
      default:  tmr_val = '0;
    endcase
  end

  assign tmr_load  = (st_d != st_q);
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign finish    = (st_q != ST_IDLE) && (st_d == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // R2: busy right after acceptance
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R6: capture only when leaving the access phase
  a_r6_capture_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (st_q == ST_RACC && tmr_zero));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl import asram_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 20,
  parameter int T_ACS_NS = 20,
  parameter int T_OE_NS  = 8,
  parameter int T_OHZ_NS = 8,
  parameter int T_CHZ_NS = 10,
  parameter int T_WHZ_NS = 10,
  parameter int T_WC_NS  = 20,
  parameter int T_WP_NS  = 13,
  parameter int T_DS_NS  = 10,
  parameter int T_DH_NS  = 0,
  parameter int T_AW_NS  = 15,
  parameter int T_AS_NS  = 0,
  parameter int T_AH_NS  = 0,
  parameter bit WE_ONLY  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_wr_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int SA_C   = ns2cyc(T_AS_NS, CLK_NS);
  localparam int GAP_C  = WE_ONLY ? ns2cyc(T_WHZ_NS, CLK_NS) : 0;
  localparam int DATA_C = imax(imax(ns2cyc(T_DS_NS, CLK_NS), ns2cyc(T_WP_NS, CLK_NS) - GAP_C),
                               imax(ns2cyc(T_AW_NS, CLK_NS) - SA_C - GAP_C, 1));
  localparam int HOLD_C = imax(ns2cyc(T_DH_NS, CLK_NS), ns2cyc(T_AH_NS, CLK_NS));
  localparam int REC_C  = imax(0, ns2cyc(T_WC_NS, CLK_NS) - (SA_C + GAP_C + DATA_C + HOLD_C));
  localparam int RACC_C = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_ACS_NS, CLK_NS)),
                               ns2cyc(T_OE_NS, CLK_NS));
  localparam int TURN_C = ns2cyc(imax(T_OHZ_NS, T_CHZ_NS), CLK_NS);
  localparam int LMAX   = imax(imax(imax(SA_C, GAP_C), imax(DATA_C, HOLD_C)),
                               imax(imax(REC_C, RACC_C), TURN_C));
  localparam int CW     = $clog2(LMAX + 1);

  // asynchronous assert, synchronous release
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  st_e           st_q, st_d;
  logic          tmr_load, tmr_zero, accept, capture, finish;
  logic [CW-1:0] tmr_val;

  asram_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_s), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  asram_seq #(
    .CW(CW), .SA_C(SA_C), .GAP_C(GAP_C), .DATA_C(DATA_C), .HOLD_C(HOLD_C),
    .REC_C(REC_C), .RACC_C(RACC_C), .TURN_C(TURN_C)
  ) u_seq (
    .clk(clk), .rst_n(rst_s), .req_valid(req_valid), .req_write(req_write),
    .tmr_zero(tmr_zero), .st_q(st_q), .st_d(st_d), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .accept(accept), .capture(capture), .finish(finish),
    .req_ready(req_ready)
  );

  // pin decode of the next state, registered so the pads see clean edges
  logic sel_d, wr_d, oe_d, drv_d;
  always_comb begin
    sel_d = (st_d == ST_WADDR) || (st_d == ST_WGAP) || (st_d == ST_WDATA) || (st_d == ST_RACC);
    wr_d  = (st_d == ST_WGAP) || (st_d == ST_WDATA);
    oe_d  = WE_ONLY ? 1'b1 : (st_d == ST_RACC);
    if (WE_ONLY) drv_d = (st_d == ST_WDATA) || (st_d == ST_WHOLD);
    else         drv_d = (st_d == ST_WADDR) || (st_d == ST_WDATA) || (st_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_wr_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      done      <= 1'b0;
    end else begin
      mem_sel_n <= !sel_d;
      mem_sel   <= sel_d;
      mem_wr_n  <= !wr_d;
      mem_oe_n  <= !oe_d;
      mem_dq_oe <= drv_d;
      done      <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mem_addr <= '0;
      mem_dq_o <= '0;
      rd_data  <= '0;
    end else begin
      if (accept)  mem_addr <= req_addr;
      if (accept)  mem_dq_o <= req_wdata;
      if (capture) rd_data  <= mem_dq_i;
    end
  end

  // R1: idle leaves the memory deselected with the bus released
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_IDLE) |-> (mem_sel_n && !mem_sel && mem_wr_n && !mem_dq_oe));
  // R4: address frozen during the write pulse
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_s)
    (!mem_wr_n && $past(!mem_wr_n)) |-> $stable(mem_addr));
  // R5: data still driven in the cycle the pulse ends
  a_r5_hold_drive: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(mem_wr_n) |-> mem_dq_oe);
  // R8: no drive just after output enable was active
  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_s)
    (!WE_ONLY && $past(!mem_oe_n)) |-> !mem_dq_oe);
  // R9: output enable off during writes
  a_r9_oe_off_write: assert property (@(posedge clk) disable iff (!rst_s)
    (!WE_ONLY && !mem_wr_n) |-> mem_oe_n);
  // R7: single-cycle completion pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int PER = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WP_C    = cyc(13);
  localparam int DS_C    = cyc(10);
  localparam int ACC_C   = mx(mx(cyc(20), cyc(20)), cyc(8));
  localparam int TRN_C   = cyc(10);
  localparam int WR_BUSY = cyc(0) + mx(mx(DS_C, WP_C), cyc(15) - cyc(0)) + mx(cyc(0), cyc(0));
  localparam int RD_BUSY = ACC_C + TRN_C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, done;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rd_data, mem_dq_o, mem_dq_i;
  logic mem_sel_n, mem_sel, mem_oe_n, mem_wr_n, mem_dq_oe;

  asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(PER)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_oe_n(mem_oe_n), .mem_wr_n(mem_wr_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, evaluated on falling edges
  logic [DW-1:0] mem [16];
  int acc_cnt = 0, we_cnt = 0, dq_cnt = 0;
  bit rd_prev = 0, we_prev = 0;
  logic [AW-1:0] addr_prev = '0, wr_addr = '0;
  logic [DW-1:0] dq_prev = '0;
  int v_r4 = 0, v_r5 = 0, v_r8 = 0, v_r9 = 0;

  wire sel_w  = !mem_sel_n && mem_sel;
  wire rd_sel = sel_w && !mem_oe_n && mem_wr_n;
  wire we_act = sel_w && !mem_wr_n;
  assign mem_dq_i = (rd_sel && acc_cnt >= ACC_C) ? mem[mem_addr] : 16'hBAD0;

  always @(negedge clk) if (rst_n) begin
    if (rd_sel) acc_cnt <= (rd_prev && mem_addr == addr_prev) ? acc_cnt + 1 : 1;
    else        acc_cnt <= 0;
    if (mem_dq_oe && (rd_sel || rd_prev)) v_r8++;
    if (we_act && !mem_oe_n) v_r9++;
    if (we_act) begin
      if (we_prev && mem_addr != wr_addr) v_r4++;
      wr_addr <= mem_addr;
      we_cnt  <= we_cnt + 1;
    end
    if (we_prev && !we_act) begin
      if (we_cnt < WP_C) v_r4++;
      if (!mem_dq_oe || dq_cnt < DS_C) v_r5++;
      mem[wr_addr] <= mem_dq_o;
      we_cnt <= 0;
    end
    if (mem_dq_oe) dq_cnt <= (dq_cnt > 0 && mem_dq_o == dq_prev) ? dq_cnt + 1 : 1;
    else           dq_cnt <= 0;
    dq_prev   <= mem_dq_o;
    rd_prev   <= rd_sel;
    we_prev   <= we_act;
    addr_prev <= mem_addr;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, output int busy);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    busy = 0;
    while (!req_ready && busy < 50) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy;
    issue(1'b1, a, d, busy);
    check(busy == WR_BUSY, "R2 write busy span", busy, WR_BUSY);
    check(done == 1'b1, "R7 done on write return", done, 1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int busy;
    issue(1'b0, a, '0, busy);
    check(busy == RD_BUSY, "R2 read busy span", busy, RD_BUSY);
    check(done == 1'b1 && rd_data == exp, "R3 R6 read data with done", rd_data, exp);
    @(negedge clk);
    check(done == 1'b0 && rd_data == exp, "R7 done drops, data held", {done, rd_data}, {1'b0, exp});
  endtask

  task automatic t_reset;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_ready && !done && mem_sel_n && !mem_sel && mem_wr_n && !mem_dq_oe,
          "R1 reset pins", {req_ready, done, mem_sel_n, mem_sel, mem_wr_n, mem_dq_oe}, 6'b101010);
  endtask

  task automatic t_patterns;
    do_write(4'd0, 16'h0000);
    do_write(4'd15, 16'hFFFF);
    do_write(4'd7, 16'hA5A5);
    do_write(4'd8, 16'h5A5A);
    do_read(4'd15, 16'hFFFF);
    do_read(4'd7, 16'hA5A5);
    do_read(4'd0, 16'h0000);
    do_read(4'd8, 16'h5A5A);
  endtask

  task automatic t_turnaround;
    // read immediately followed by write, then overwrite check
    do_read(4'd7, 16'hA5A5);
    do_write(4'd7, 16'h1234);
    do_read(4'd7, 16'h1234);
    do_write(4'd3, 16'hC3C3);
    do_write(4'd4, 16'h3C3C);
    do_read(4'd3, 16'hC3C3);
    do_read(4'd4, 16'h3C3C);
  endtask

  task automatic t_final;
    @(negedge clk);
    check(mem_sel_n && !mem_sel && mem_wr_n && !mem_dq_oe && req_ready,
          "R1 idle pins after traffic", {mem_sel_n, mem_sel, mem_wr_n, mem_dq_oe}, 4'b1010);
    check(v_r4 == 0, "R4 write pulse width / address", v_r4, 0);
    check(v_r5 == 0, "R5 data setup and hold", v_r5, 0);
    check(v_r8 == 0, "R8 bus turnaround", v_r8, 0);
    check(v_r9 == 0, "R9 output enable during write", v_r9, 0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_turnaround();
    t_final();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule